// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block models a synchronous static RAM. Each word holds two 9-bit lanes. A lane carries eight data bits and one parity bit. With `ADDR_W` = 16 the array holds 64K words. The default is a smaller array so that elaboration stays light. Reads and writes start from one of two address strobes, chip selection is qualified on the clock edge, and a 2-bit burst counter then steps through up to four words. It can step in linear or in exclusive-or (interleaved) order.

Writes are decided on the clock edge:
- A global write stores both lanes.
- Otherwise a lane-write enable together with per-lane selects chooses which lanes change.
- A cycle that writes no lane is a read.

Read data is registered and appears on the shared data bus after the edge that sampled the address. The bus drivers follow an asynchronous active-low output enable. The first read after a deselected period never drives the bus. A sleep input freezes all activity, keeps the stored contents and releases the bus.

Top module: `sram_burst`

## Requirements
- R1: Each word is `2 * 9` bits. Lane 0 is `data[8:0]` and lane 1 is `data[17:9]`, each with bit 8 of the lane as parity. A stored word reads back bit-exact.
- R2: When `all_wr_n` is low at an edge of a selected cycle, both lanes are written whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R3: When `all_wr_n` is high and `lane_wr_en_n` is low, lane k is written exactly when `lane_sel_n[k]` is low. Unselected lanes keep their contents.
- R4: A selected cycle that writes no lane is a read. Bus contents in that cycle are not stored.
- R5: Read data for the address sampled at edge k is driven from just after edge k until just after edge k+1.
- R6: A new address is loaded when `ctl_strobe_n` is low, or when `cpu_strobe_n` is low while `sel_a_n` is low. `cpu_strobe_n` has no effect while `sel_a_n` is high. On a load the device is selected only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise it is deselected, and no reads or writes occur until the next selecting load.
- R7: Without a load, `next_n` low advances a 2-bit counter; otherwise the address holds. The low two address bits are base+count mod 4 when `burst_xor`=0, and base XOR count when `burst_xor`=1. The upper bits stay at the base.
- R8: `out_en_n` high releases the bus at once, with no clock edge needed.
- R9: The first read after a deselected state does not drive the bus even with `out_en_n` low. A following read does drive it.
- R10: While `sleep` is high at an edge, nothing is read or written, the burst address and selection are kept, and the bus is released.
- R11: While `rst_n` is low the device is deselected and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of selection and read pipeline |
| addr | input | ADDR_W | Word address, loaded on a strobe |
| cpu_strobe_n | input | 1 | Active-low address strobe, valid only while sel_a_n is low |
| ctl_strobe_n | input | 1 | Active-low address strobe, always valid |
| next_n | input | 1 | Active-low burst advance |
| sel_a_n | input | 1 | Active-low chip select, also gates cpu_strobe_n |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| all_wr_n | input | 1 | Active-low global write |
| lane_wr_en_n | input | 1 | Active-low enable for lane writes |
| lane_sel_n | input | 2 | Active-low per-lane write selects |
| out_en_n | input | 1 | Asynchronous active-low bus output enable |
| sleep | input | 1 | Active-high low-activity state |
| burst_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| data | inout | 18 | Shared data bus, two 9-bit lanes |

## Verification
Writes take effect at the edge where the write controls are sampled. A read of that word on the next selected cycle therefore sees the new contents. Read data and its drive enable come from the edge that sampled the address, so the bench samples the bus 1 ns after that edge and before any new input is applied. Output-enable and sleep effects on the bus are combinational, so they are checked 1 ns after the control changes, with no edge in between. A bench reference model advances once per edge from the same inputs and predicts the bus value for the cycle that follows.

// File: rtl/sram_burst.sv
module sram_burst #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              next_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic              burst_xor,
  inout  wire  [DATA_W-1:0] data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              act_q;
  logic              rd_vld_q;
  logic [DATA_W-1:0] rd_q;

  wire load    = !ctl_strobe_n || (!cpu_strobe_n && !sel_a_n);
  wire chip_on = !sel_a_n && sel_b && !sel_c_n;
  wire live    = load ? chip_on : act_q;

  wire [ADDR_W-1:0] base_nx = load ? addr : base_q;
  wire [1:0]        cnt_nx  = load ? 2'd0 : (!next_n ? cnt_q + 2'd1 : cnt_q);
  wire [1:0]        low     = burst_xor ? (base_nx[1:0] ^ cnt_nx) : (base_nx[1:0] + cnt_nx);
  wire [ADDR_W-1:0] cur     = {base_nx[ADDR_W-1:2], low};

  wire [LANES-1:0] wr_lane = !all_wr_n ? {LANES{1'b1}} :
                             (!lane_wr_en_n ? ~lane_sel_n : {LANES{1'b0}});
  wire do_wr = live && !sleep && (wr_lane != '0);
  wire do_rd = live && !sleep && (wr_lane == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      rd_vld_q <= 1'b0;
    end else if (sleep) begin
      rd_vld_q <= 1'b0;
    end else begin
      act_q    <= live;
      rd_vld_q <= do_rd && act_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) begin
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
    end
    if (do_rd) rd_q <= mem[cur];
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int k = 0; k < LANES; k++) begin
        if (wr_lane[k]) mem[cur][k*LANE_W +: LANE_W] <= data[k*LANE_W +: LANE_W];
      end
    end
  end

  assign data = (rd_vld_q && !out_en_n && !sleep) ? rd_q : {DATA_W{1'bz}};
endmodule

module sram_burst_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              all_wr_n,
  input logic              lane_wr_en_n,
  input logic              sleep,
  input logic              act,
  input logic              rd_vld,
  input logic [ADDR_W-1:0] base
);
  wire ld  = !ctl_strobe_n || (!cpu_strobe_n && !sel_a_n);
  wire on  = !sel_a_n && sel_b && !sel_c_n;

  // R2
  global_write_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_wr_n && !sleep) |=> !rd_vld);
  // R4
  plain_cycle_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && act && !ld && all_wr_n && lane_wr_en_n) |=> rd_vld);
  // R6
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !on && !sleep) |=> (!rd_vld && !act));
  // R9
  first_read_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> !rd_vld);
  // R10
  sleep_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_vld);
  // R10
  sleep_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(base) && $stable(act)));
endmodule

bind sram_burst sram_burst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .all_wr_n(all_wr_n),
  .lane_wr_en_n(lane_wr_en_n), .sleep(sleep), .act(act_q), .rd_vld(rd_vld_q), .base(base_q)
);

// File: tb/test_sram_burst.sv
module test_sram_burst;
  localparam int AW = 10;
  localparam int DW = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cpu_strobe_n, ctl_strobe_n, next_n, sel_a_n, sel_b, sel_c_n;
  logic all_wr_n, lane_wr_en_n, out_en_n, sleep, burst_xor, tb_drv;
  logic [1:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] tb_dq;
  wire  [DW-1:0] data;

  assign data = tb_drv ? tb_dq : {DW{1'bz}};
  for (genvar g = 0; g < DW; g++) begin : g_pd
    pulldown (data[g]);
  end

  sram_burst #(.ADDR_W(AW)) i_sram_burst (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .next_n(next_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
    .burst_xor(burst_xor), .data(data)
  );

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] ref_mem [16];
  logic          m_act = 1'b0, m_vis = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [DW-1:0] m_data = '0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_bus();
    return (m_vis && !out_en_n && !sleep) ? m_data : '0;
  endfunction

  task automatic model_edge();
    logic ld, live;
    logic [1:0] wr, lo;
    logic [AW-1:0] cur;
    if (!rst_n) begin m_act = 0; m_vis = 0; return; end
    if (sleep) begin m_vis = 0; return; end
    ld   = !ctl_strobe_n || (!cpu_strobe_n && !sel_a_n);
    live = ld ? (!sel_a_n && sel_b && !sel_c_n) : m_act;
    if (ld) begin m_base = addr; m_cnt = 0; end
    else if (!next_n) m_cnt = m_cnt + 2'd1;
    lo  = burst_xor ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    cur = {m_base[AW-1:2], lo};
    wr  = !all_wr_n ? 2'b11 : (!lane_wr_en_n ? ~lane_sel_n : 2'b00);
    m_vis = 1'b0;
    if (live && wr != 0) begin
      if (wr[0]) ref_mem[cur[3:0]][8:0]  = tb_dq[8:0];
      if (wr[1]) ref_mem[cur[3:0]][17:9] = tb_dq[17:9];
    end else if (live) begin
      m_data = ref_mem[cur[3:0]];
      m_vis  = m_act;
    end
    m_act = live;
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; next_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    all_wr_n = 1; lane_wr_en_n = 1; lane_sel_n = 2'b11; out_en_n = 0; sleep = 0;
    tb_drv = 0;
  endtask

  task automatic release_bus();
    tb_drv = 0; out_en_n = 0; #1;
  endtask

  task automatic write_word(logic [3:0] a, logic [DW-1:0] d, logic gw, logic bwe, logic [1:0] bs);
    idle(); out_en_n = 1; ctl_strobe_n = 0; addr = {{(AW-4){1'b0}}, a};
    all_wr_n = gw; lane_wr_en_n = bwe; lane_sel_n = bs; tb_drv = 1; tb_dq = d;
    step(); release_bus();
  endtask

  task automatic read_start(logic [3:0] a);
    idle(); ctl_strobe_n = 0; addr = {{(AW-4){1'b0}}, a}; step();
  endtask

  task automatic burst(logic xr, logic [3:0] a, string req);
    burst_xor = xr;
    read_start(a); chk(req, data, exp_bus());
    chk(req, data, ref_mem[a]);
    for (int i = 1; i < 4; i++) begin
      idle(); next_n = 0; step(); chk(req, data, exp_bus());
    end
    idle(); step(); chk({req, " hold"}, data, exp_bus());
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); burst_xor = 0; addr = '0; tb_dq = '0; rst_n = 0;
    step(); step();
    // R11: reset leaves the bus released
    chk("R11", data, 18'h0);
    rst_n = 1;

    for (int i = 0; i < 16; i++) write_word(i[3:0], 18'h2_0000 | ($urandom & 18'h3_ffff) | 18'h1, 0, 1, 2'b11);

    // R1 R5: read after writes is visible after one edge
    idle(); ctl_strobe_n = 0; addr = 10'd3; step();
    chk("R5", data, ref_mem[3]);
    chk("R1", data, exp_bus());

    // R8: output enable acts without a clock edge
    out_en_n = 1; #1; chk("R8", data, 18'h0);
    out_en_n = 0; #1; chk("R8", data, ref_mem[3]);

    // R6 R9: deselect, then first read masked, second driven
    idle(); ctl_strobe_n = 0; sel_b = 0; step(); chk("R6", data, 18'h0);
    read_start(4'd5); chk("R9", data, 18'h0);
    idle(); step(); chk("R9", data, ref_mem[5]);

    // R2: global write beats lane controls
    write_word(4'd7, 18'h2_a5c3, 0, 0, 2'b11);
    read_start(4'd7); chk("R2", data, 18'h2_a5c3);

    // R3: single-lane writes
    write_word(4'd8, 18'h1_2345, 1, 0, 2'b01);
    read_start(4'd8); chk("R3", data, exp_bus());
    write_word(4'd9, 18'h0_01fe, 1, 0, 2'b10);
    read_start(4'd9); chk("R3", data, exp_bus());
    chk("R3", data[8:0], 9'h1fe);

    // R4: no lane selected means a read; bus value not stored
    idle(); out_en_n = 1; ctl_strobe_n = 0; addr = 10'd10; lane_wr_en_n = 0;
    tb_drv = 1; tb_dq = 18'h3_3333; step(); release_bus();
    chk("R4", data, ref_mem[10]);

    // R6: processor strobe ignored while sel_a_n high
    read_start(4'd4);
    idle(); cpu_strobe_n = 0; sel_a_n = 1; addr = 10'd12; step();
    chk("R6", data, ref_mem[4]);
    idle(); cpu_strobe_n = 0; addr = 10'd12; step();
    chk("R6", data, ref_mem[12]);

    // R7: burst orders
    burst(0, 4'd13, "R7 linear");
    burst(1, 4'd13, "R7 xor");
    burst(0, 4'd1,  "R7 linear");
    burst(1, 4'd6,  "R7 xor");

    // R10: sleep freezes burst, releases bus, blocks writes
    burst_xor = 0; read_start(4'd0);
    idle(); sleep = 1; next_n = 0; step(); chk("R10", data, 18'h0);
    step(); chk("R10", data, 18'h0);
    idle(); step(); chk("R10", data, ref_mem[0]);
    idle(); sleep = 1; out_en_n = 1; ctl_strobe_n = 0; addr = 10'd2; all_wr_n = 0;
    tb_drv = 1; tb_dq = 18'h0_0bad; step(); release_bus();
    idle(); step(); chk("R10", data, ref_mem[0]);
    read_start(4'd2); chk("R10", data, exp_bus());

    // Random mix checked against the reference model (R1 R3 R5 R7 R9)
    for (int n = 0; n < 600; n++) begin
      idle();
      burst_xor = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: ctl_strobe_n = 0;
        1: cpu_strobe_n = 0;
        default: ;
      endcase
      addr = {{(AW-4){1'b0}}, 4'($urandom)};
      sel_a_n = ($urandom_range(0, 7) == 0);
      sel_b   = ($urandom_range(0, 7) != 0);
      next_n  = $urandom_range(0, 1);
      all_wr_n = ($urandom_range(0, 3) != 0);
      lane_wr_en_n = $urandom_range(0, 1);
      lane_sel_n = 2'($urandom);
      sleep = ($urandom_range(0, 9) == 0);
      if (!all_wr_n || (!lane_wr_en_n && lane_sel_n != 2'b11)) begin
        out_en_n = 1; tb_drv = 1; tb_dq = 18'($urandom);
      end
      step();
      tb_drv = 0; out_en_n = ($urandom_range(0, 4) == 0); #1;
      chk("R5 random", data, exp_bus());
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule